// File: doc/BRIEF.md
# Variable Page Size Fully Associative Translation Buffer

This block is a 64-entry, fully associative address translation buffer. Instruction and data accesses share it, and software maintains it. Each entry has two words.

- **Tag word.** It holds an effective page number, a 3-bit page size code and a valid flag. The page size ranges from 1 KB to 16 MB. The size sets how many upper address bits take part in the compare.
- **Data word.** It holds a real page number, execute and write permissions, a 4-bit zone select and four storage attribute bits (write-through, cache-inhibit, coherent, guarded).

A command port serves software. It reads either word of an entry by index, writes either word of an entry by index, or searches all valid entries for an effective address and returns the lowest matching index. The search address travels on the same data input that a write uses.

A separate lookup port serves the pipeline. It takes an effective address and an access type. It returns a hit flag, the physical address, the zone select, the attributes and a permission fault flag. All results are registered.

Top module: `vpsz_tlb`

## Requirements
- R1: Any of the 64 entries can be written and read back by index. Word select 0 is the tag and word select 1 is the data. The data word reads back all 32 bits. The tag word keeps bits [31:10] (page number), [9:7] (size code) and bit 6 (valid), and reads zero in bits [5:0].
- R2: After reset every tag and data word reads zero, and every lookup misses.
- R3: An entry with size code n (0..7, meaning 1K, 4K, 16K, 64K, 256K, 1M, 4M, 16M) matches when effective address bits [31:10+2n] equal the same bits of its page number. Lower bits are ignored.
- R4: On a hit the physical address takes bits [31:10+2n] from the real page number (data bits [31:10]) and the bits below from the effective address.
- R5: An entry whose valid bit (tag bit 6) is clear never matches, neither in a lookup nor in a search.
- R6: A search reports found=1 and the lowest matching index. With no match it reports found=0 and index 0.
- R7: When several entries match a lookup, the lowest-indexed one supplies the translation.
- R8: On a hit, zone select comes from data bits [7:4] and attributes from data bits [3:0]. On a miss, hit, address, zone, attributes and fault are all 0.
- R9: Access type 2 (fetch) faults on a hit whose execute bit (data bit 9) is clear. Access type 1 (store) faults on a hit whose write bit (data bit 8) is clear. Type 0 (load) never faults, and a miss never faults.
- R10: Read and search responses, and lookup results, appear exactly one clock after the request. A lookup issued in the same cycle as a write sees the contents before that write.
- R11: The command op codes are 0 read, 1 write, 2 search and 3 no-op. Writes and no-ops give no response. A no-op changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 read, 1 write, 2 search, 3 no-op |
| cmd_idx_i | input | 6 | Entry index for read and write |
| cmd_word_i | input | 1 | 0 tag word, 1 data word |
| cmd_data_i | input | 32 | Write data, or search effective address |
| rsp_valid_o | output | 1 | Read or search response strobe |
| rsp_rdata_o | output | 32 | Read data (0 for a search) |
| rsp_found_o | output | 1 | Search matched |
| rsp_idx_o | output | 6 | Lowest matching index |
| lk_valid_i | input | 1 | Lookup strobe |
| lk_ea_i | input | 32 | Lookup effective address |
| lk_acc_i | input | 2 | 0 load, 1 store, 2 fetch |
| lk_valid_o | output | 1 | Lookup result strobe |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pa_o | output | 32 | Physical address |
| lk_zone_o | output | 4 | Zone select |
| lk_attr_o | output | 4 | Storage attributes |
| lk_fault_o | output | 1 | Permission fault |

## Verification
Every result of this block sits one register behind its request. That covers read data, search found and index, and the whole lookup result. A write becomes visible to lookups and reads from the cycle after its edge.

The bench drives each request on a falling edge and samples the outputs at the next falling edge, so it reads exactly one rising edge later. Read-backs after a write are issued as separate later commands.

One scenario drives a write and a lookup on the same edge, and expects the lookup to report the old contents.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned PN_W = 22;
  localparam int unsigned SZ_W = 3;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_SEARCH = 2'd2,
    OP_NONE   = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic [PN_W-1:0] epn;
    logic [SZ_W-1:0] size;
    logic            valid;
  } tag_t;

  typedef struct packed {
    logic [PN_W-1:0] rpn;
    logic            ex;
    logic            wr;
    logic [3:0]      zone;
    logic [3:0]      attr;
  } data_t;

  // upper-bit mask for a size code: bits below 10+2n cleared
  function automatic logic [31:0] page_mask(input logic [SZ_W-1:0] sz);
    logic [4:0] sh;
    sh = 5'd10 + {1'b0, sz, 1'b0};
    return 32'hFFFF_FFFF << sh;
  endfunction

  function automatic logic [31:0] tag_to_word(input tag_t t);
    return {t.epn, t.size, t.valid, 6'b0};
  endfunction

  function automatic tag_t word_to_tag(input logic [31:0] w);
    tag_t t;
    t.epn   = w[31:10];
    t.size  = w[9:7];
    t.valid = w[6];
    return t;
  endfunction
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry
  import tlb_pkg::*;
#(
  parameter int unsigned N_CMP = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_tag_i,
  input  logic                  we_data_i,
  input  logic [31:0]           wdata_i,
  input  logic [N_CMP-1:0][31:0] ea_i,
  output tag_t                  tag_o,
  output data_t                 data_o,
  output logic [N_CMP-1:0]      match_o
);
  tag_t  tag_q;
  data_t data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= '0;
      data_q <= '0;
    end else begin
      if (we_tag_i)  tag_q  <= word_to_tag(wdata_i);
      if (we_data_i) data_q <= data_t'(wdata_i);
    end
  end

  logic [31:0] mask;
  logic [31:0] base;
  assign mask = page_mask(tag_q.size);
  assign base = {tag_q.epn, 10'b0};

  for (genvar p = 0; p < N_CMP; p++) begin : g_cmp
    assign match_o[p] = tag_q.valid && (((ea_i[p] ^ base) & mask) == 32'd0);
  end

  assign tag_o  = tag_q;
  assign data_o = data_q;
endmodule

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
  parameter int unsigned N = 64,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign found_o = |vec_i;
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
(
  input  logic        hit_i,
  input  logic [31:0] ea_i,
  input  logic [1:0]  acc_i,
  input  tag_t        tag_i,
  input  data_t       data_i,
  output logic [31:0] pa_o,
  output logic [3:0]  zone_o,
  output logic [3:0]  attr_o,
  output logic        fault_o
);
  logic [31:0] mask;
  logic        no_ex, no_wr;

  assign mask  = page_mask(tag_i.size);
  assign no_ex = (acc_e'(acc_i) == ACC_FETCH) && !data_i.ex;
  assign no_wr = (acc_e'(acc_i) == ACC_STORE) && !data_i.wr;

  always_comb begin
    pa_o    = '0;
    zone_o  = '0;
    attr_o  = '0;
    fault_o = 1'b0;
    if (hit_i) begin
      pa_o    = ({data_i.rpn, 10'b0} & mask) | (ea_i & ~mask);
      zone_o  = data_i.zone;
      attr_o  = data_i.attr;
      fault_o = no_ex || no_wr;
    end
  end
endmodule

// File: rtl/vpsz_tlb.sv
module vpsz_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [IDX_W-1:0] cmd_idx_i,
  input  logic             cmd_word_i,
  input  logic [31:0]      cmd_data_i,
  output logic             rsp_valid_o,
  output logic [31:0]      rsp_rdata_o,
  output logic             rsp_found_o,
  output logic [IDX_W-1:0] rsp_idx_o,
  input  logic             lk_valid_i,
  input  logic [31:0]      lk_ea_i,
  input  logic [1:0]       lk_acc_i,
  output logic             lk_valid_o,
  output logic             lk_hit_o,
  output logic [31:0]      lk_pa_o,
  output logic [3:0]       lk_zone_o,
  output logic [3:0]       lk_attr_o,
  output logic             lk_fault_o
);
  localparam int unsigned CMP_LK = 0;
  localparam int unsigned CMP_SR = 1;

  cmd_op_e op;
  assign op = cmd_op_e'(cmd_op_i);

  logic [1:0][31:0]  cmp_ea;
  tag_t              tag_arr   [ENTRIES];
  data_t             data_arr  [ENTRIES];
  logic [1:0]        match_arr [ENTRIES];
  logic [ENTRIES-1:0] we_tag, we_data, lk_vec, sr_vec;

  assign cmp_ea[CMP_LK] = lk_ea_i;
  assign cmp_ea[CMP_SR] = cmd_data_i;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign we_tag[e]  = cmd_valid_i && (op == OP_WRITE) && (cmd_idx_i == IDX_W'(e)) && !cmd_word_i;
    assign we_data[e] = cmd_valid_i && (op == OP_WRITE) && (cmd_idx_i == IDX_W'(e)) &&  cmd_word_i;
    assign lk_vec[e]  = match_arr[e][CMP_LK];
    assign sr_vec[e]  = match_arr[e][CMP_SR];

    tlb_entry #(.N_CMP(2)) u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_tag_i  (we_tag[e]),
      .we_data_i (we_data[e]),
      .wdata_i   (cmd_data_i),
      .ea_i      (cmp_ea),
      .tag_o     (tag_arr[e]),
      .data_o    (data_arr[e]),
      .match_o   (match_arr[e])
    );
  end

  logic             lk_found, sr_found;
  logic [IDX_W-1:0] lk_idx, sr_idx;

  tlb_first_set #(.N(ENTRIES)) u_lk_pri (.vec_i(lk_vec), .found_o(lk_found), .idx_o(lk_idx));
  tlb_first_set #(.N(ENTRIES)) u_sr_pri (.vec_i(sr_vec), .found_o(sr_found), .idx_o(sr_idx));

  logic [31:0] pa_c;
  logic [3:0]  zone_c, attr_c;
  logic        fault_c;

  tlb_xlate u_xlate (
    .hit_i   (lk_found),
    .ea_i    (lk_ea_i),
    .acc_i   (lk_acc_i),
    .tag_i   (tag_arr[lk_idx]),
    .data_i  (data_arr[lk_idx]),
    .pa_o    (pa_c),
    .zone_o  (zone_c),
    .attr_o  (attr_c),
    .fault_o (fault_c)
  );

  logic [31:0] rd_word;
  assign rd_word = cmd_word_i ? 32'(data_arr[cmd_idx_i]) : tag_to_word(tag_arr[cmd_idx_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      rsp_found_o <= 1'b0;
      rsp_idx_o   <= '0;
    end else begin
      rsp_valid_o <= cmd_valid_i && (op == OP_READ || op == OP_SEARCH);
      if (cmd_valid_i && op == OP_READ) begin
        rsp_rdata_o <= rd_word;
        rsp_found_o <= 1'b0;
        rsp_idx_o   <= '0;
      end else if (cmd_valid_i && op == OP_SEARCH) begin
        rsp_rdata_o <= '0;
        rsp_found_o <= sr_found;
        rsp_idx_o   <= sr_idx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_valid_o <= 1'b0;
      lk_hit_o   <= 1'b0;
      lk_pa_o    <= '0;
      lk_zone_o  <= '0;
      lk_attr_o  <= '0;
      lk_fault_o <= 1'b0;
    end else begin
      lk_valid_o <= lk_valid_i;
      lk_hit_o   <= lk_valid_i && lk_found;
      lk_pa_o    <= lk_valid_i ? pa_c    : '0;
      lk_zone_o  <= lk_valid_i ? zone_c  : '0;
      lk_attr_o  <= lk_valid_i ? attr_c  : '0;
      lk_fault_o <= lk_valid_i && fault_c;
    end
  end
endmodule

// File: rtl/vpsz_tlb_checker.sv
module vpsz_tlb_checker #(
  parameter int unsigned ENTRIES = 64,
  localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [1:0]       cmd_op_i,
  input logic [IDX_W-1:0] cmd_idx_i,
  input logic             cmd_word_i,
  input logic [31:0]      cmd_data_i,
  input logic             rsp_valid_o,
  input logic [31:0]      rsp_rdata_o,
  input logic             rsp_found_o,
  input logic [IDX_W-1:0] rsp_idx_o,
  input logic             lk_valid_i,
  input logic [31:0]      lk_ea_i,
  input logic [1:0]       lk_acc_i,
  input logic             lk_valid_o,
  input logic             lk_hit_o,
  input logic [31:0]      lk_pa_o,
  input logic [3:0]       lk_zone_o,
  input logic [3:0]       lk_attr_o,
  input logic             lk_fault_o
);
  assert_pa_low_bits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_pa_o[9:0] == $past(lk_ea_i[9:0]));

  assert_no_search_idx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_found_o) |-> rsp_idx_o == '0);

  assert_miss_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_o && !lk_hit_o) |-> (lk_pa_o == '0 && lk_zone_o == '0 && lk_attr_o == '0));

  assert_load_no_fault_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_acc_i == 2'd0) |=> !lk_fault_o);

  assert_fault_needs_hit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_fault_o |-> lk_hit_o);

  assert_read_rsp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 2'd0) |=> (rsp_valid_o && !rsp_found_o));

  assert_lk_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> lk_valid_o);

  assert_write_silent_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (cmd_op_i == 2'd1 || cmd_op_i == 2'd3)) |=> !rsp_valid_o);
endmodule

bind vpsz_tlb vpsz_tlb_checker #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/vpsz_tlb_bench.sv
module vpsz_tlb_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [1:0]  cmd_op_i = '0;
  logic [5:0]  cmd_idx_i = '0;
  logic        cmd_word_i = 1'b0;
  logic [31:0] cmd_data_i = '0;
  logic        rsp_valid_o, rsp_found_o;
  logic [31:0] rsp_rdata_o;
  logic [5:0]  rsp_idx_o;
  logic        lk_valid_i = 1'b0;
  logic [31:0] lk_ea_i = '0;
  logic [1:0]  lk_acc_i = '0;
  logic        lk_valid_o, lk_hit_o, lk_fault_o;
  logic [31:0] lk_pa_o;
  logic [3:0]  lk_zone_o, lk_attr_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vpsz_tlb u_vpsz_tlb (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_idx_i(cmd_idx_i),
    .cmd_word_i(cmd_word_i), .cmd_data_i(cmd_data_i),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .rsp_found_o(rsp_found_o), .rsp_idx_o(rsp_idx_o),
    .lk_valid_i(lk_valid_i), .lk_ea_i(lk_ea_i), .lk_acc_i(lk_acc_i),
    .lk_valid_o(lk_valid_o), .lk_hit_o(lk_hit_o), .lk_pa_o(lk_pa_o),
    .lk_zone_o(lk_zone_o), .lk_attr_o(lk_attr_o), .lk_fault_o(lk_fault_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_tag(input logic [31:0] ea, input int n, input bit v);
    return (ea & 32'hFFFF_FC00) | (32'(n) << 7) | (v ? 32'h40 : 32'h0);
  endfunction

  function automatic logic [31:0] low_mask(input int n);
    return (32'd1 << (10 + 2 * n)) - 32'd1;
  endfunction

  task automatic cmd(input logic [1:0] op, input int idx, input bit word, input logic [31:0] d);
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_idx_i = 6'(idx); cmd_word_i = word; cmd_data_i = d;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic wr(input int idx, input bit word, input logic [31:0] d);
    cmd(2'd1, idx, word, d);
  endtask

  task automatic rd(input int idx, input bit word);
    cmd(2'd0, idx, word, 32'd0);
  endtask

  task automatic srch(input logic [31:0] ea);
    cmd(2'd2, 0, 1'b0, ea);
  endtask

  task automatic lk(input logic [31:0] ea, input logic [1:0] acc);
    @(negedge clk);
    lk_valid_i = 1'b1; lk_ea_i = ea; lk_acc_i = acc;
    @(negedge clk);
    lk_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    rd(0, 1'b0);  chk("R2 tag0 zero", rsp_rdata_o, 32'd0);
    rd(63, 1'b1); chk("R2 data63 zero", rsp_rdata_o, 32'd0);
    lk(32'h0, 2'd0);
    chk("R2 lookup miss", {31'd0, lk_hit_o}, 32'd0);
    chk("R8 miss pa zero", lk_pa_o, 32'd0);
  endtask

  task automatic t_rw;
    wr(5, 1'b0, 32'h1234_57FF);
    wr(5, 1'b1, 32'hDEAD_BEEF);
    wr(63, 1'b1, 32'h0BAD_F00D);
    rd(5, 1'b0);  chk("R1 tag readback", rsp_rdata_o, 32'h1234_57C0);
    chk("R10 read rsp valid", {31'd0, rsp_valid_o}, 32'd1);
    rd(5, 1'b1);  chk("R1 data readback", rsp_rdata_o, 32'hDEAD_BEEF);
    rd(63, 1'b1); chk("R1 data63 readback", rsp_rdata_o, 32'h0BAD_F00D);
    cmd(2'd3, 5, 1'b1, 32'h0);
    chk("R11 noop no response", {31'd0, rsp_valid_o}, 32'd0);
    rd(5, 1'b1);  chk("R11 noop kept data", rsp_rdata_o, 32'hDEAD_BEEF);
    wr(5, 1'b0, 32'h0);
    wr(5, 1'b1, 32'h0);
    wr(63, 1'b1, 32'h0);
  endtask

  task automatic t_sizes;
    logic [31:0] base, dword, ea_in, ea_out, m;
    base  = 32'h5A5A_5400;
    dword = 32'hC3C3_C35A;
    wr(10, 1'b1, dword);
    for (int n = 0; n < 8; n++) begin
      m = low_mask(n);
      wr(10, 1'b0, mk_tag(base, n, 1'b1));
      ea_in  = (base & ~m) | (m - 32'd3);
      ea_out = ea_in ^ (m + 32'd1);
      lk(ea_in, 2'd0);
      chk($sformatf("R3 hit size %0d", n), {31'd0, lk_hit_o}, 32'd1);
      chk($sformatf("R4 pa size %0d", n), lk_pa_o, (dword & ~m) | (ea_in & m));
      lk(ea_out, 2'd0);
      chk($sformatf("R3 miss size %0d", n), {31'd0, lk_hit_o}, 32'd0);
    end
    lk(ea_in, 2'd0);
    chk("R8 zone", {28'd0, lk_zone_o}, 32'h5);
    chk("R8 attr", {28'd0, lk_attr_o}, 32'hA);
    wr(10, 1'b0, 32'h0);
    wr(10, 1'b1, 32'h0);
  endtask

  task automatic t_search_prio;
    wr(40, 1'b0, mk_tag(32'h2000_0000, 7, 1'b1));
    wr(40, 1'b1, 32'h7700_0330);
    wr(20, 1'b0, mk_tag(32'h2012_3400, 1, 1'b1));
    wr(20, 1'b1, 32'h8800_0390);
    lk(32'h2012_3456, 2'd0);
    chk("R7 lowest zone", {28'd0, lk_zone_o}, 32'h9);
    srch(32'h2012_3456);
    chk("R6 found", {31'd0, rsp_found_o}, 32'd1);
    chk("R6 lowest idx", {26'd0, rsp_idx_o}, 32'd20);
    srch(32'h2100_0000);
    chk("R6 not found", {31'd0, rsp_found_o}, 32'd0);
    chk("R6 idx zero", {26'd0, rsp_idx_o}, 32'd0);
    srch(32'h20FF_0000);
    chk("R6 idx 40", {26'd0, rsp_idx_o}, 32'd40);
    wr(20, 1'b0, mk_tag(32'h2012_3400, 1, 1'b0));
    lk(32'h2012_3456, 2'd0);
    chk("R5 invalid skipped zone", {28'd0, lk_zone_o}, 32'h3);
    srch(32'h2012_3456);
    chk("R5 search skips invalid", {26'd0, rsp_idx_o}, 32'd40);
    wr(40, 1'b0, mk_tag(32'h2000_0000, 7, 1'b0));
    lk(32'h2012_3456, 2'd0);
    chk("R5 all invalid miss", {31'd0, lk_hit_o}, 32'd0);
  endtask

  task automatic t_perm;
    wr(30, 1'b0, mk_tag(32'h1000_0000, 1, 1'b1));
    wr(30, 1'b1, 32'h4000_0100);
    lk(32'h1000_0010, 2'd2);
    chk("R9 fetch no ex faults", {31'd0, lk_fault_o}, 32'd1);
    lk(32'h1000_0010, 2'd1);
    chk("R9 store wr ok", {31'd0, lk_fault_o}, 32'd0);
    wr(30, 1'b1, 32'h4000_0200);
    lk(32'h1000_0010, 2'd1);
    chk("R9 store no wr faults", {31'd0, lk_fault_o}, 32'd1);
    lk(32'h1000_0010, 2'd2);
    chk("R9 fetch ex ok", {31'd0, lk_fault_o}, 32'd0);
    wr(30, 1'b1, 32'h4000_0000);
    lk(32'h1000_0010, 2'd0);
    chk("R9 load never faults", {31'd0, lk_fault_o}, 32'd0);
    lk(32'h1100_0010, 2'd2);
    chk("R9 miss no fault", {31'd0, lk_fault_o}, 32'd0);
    wr(30, 1'b0, 32'h0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cmd_valid_i = 1'b1; cmd_op_i = 2'd1; cmd_idx_i = 6'd50; cmd_word_i = 1'b0;
    cmd_data_i = mk_tag(32'h3000_0000, 0, 1'b1);
    lk_valid_i = 1'b1; lk_ea_i = 32'h3000_0004; lk_acc_i = 2'd0;
    @(negedge clk);
    cmd_valid_i = 1'b0; lk_valid_i = 1'b0;
    chk("R10 lookup sees old", {31'd0, lk_hit_o}, 32'd0);
    lk(32'h3000_0004, 2'd0);
    chk("R10 lookup sees new", {31'd0, lk_hit_o}, 32'd1);
    wr(50, 1'b0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_sizes();
    t_search_prio();
    t_perm();
    t_same_cycle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule